// File: doc/BRIEF.md
# LIN Transmit Fault Supervisor

This block protects a LIN transmitter against two fault conditions: the transmit data input held at the dominant (low) level for too long, and a short on the receive line, which an analog sensor outside the block reports. When either fault appears, the block turns off the transmit enable. It also sets a sticky fault flag, and it sets a receive-only control bit that keeps the driver off until software clears it. An interrupt request follows the flags whenever the LIN interrupt mask bit is set.

Turning the transmitter back on and clearing a flag are two separate actions. The transmitter returns on its own once the fault has gone. A dominant fault ends when TxD goes high. A receive-line short ends when the short indication drops, RxD changes level and TxD is high. A flag clears only when software reads the status, and only if the matching fault is no longer present at the moment of that read. The dominant timeout is a count of clock cycles set by a parameter. All outputs are registered and the reset is synchronous.

Top module: `lin_txfault_sup`

## Requirements
- R1: If TxD is sampled low on TIMEOUT consecutive clock edges, then at the last of those edges tx_en_o drops to 0 and txdom_o becomes 1. A low run of TIMEOUT-1 edges has no effect.
- R2: After a dominant trip, tx_en_o returns to 1 at the first edge that samples TxD high, provided no other inhibit is active. txdom_o stays set.
- R3: A status read clears txdom_o only if TxD is sampled high in the same cycle. A read while TxD is low leaves the flag at 1.
- R4: An edge that samples short_det_i high sets rxshort_o to 1 and tx_en_o to 0 at that edge.
- R5: After a short, the transmit inhibit is released only at an edge where short_det_i is low, TxD is high and RxD differs from its value at the previous edge. The rxshort_o flag is not changed by this release.
- R6: A status read clears rxshort_o only if short_det_i is low in the same cycle. A read during the short leaves the flag at 1.
- R7: irq_o is 1 exactly when the mask input was 1 at the last edge and at least one fault flag is set after that edge. With the mask at 0, irq_o stays 0.
- R8: A write strobe loads the receive-only bit from the write data. While the bit is 1, or while normal_mode_i is 0, tx_en_o is 0.
- R9: A dominant trip, or any cycle in which short_det_i is high, sets the receive-only bit. This automatic set takes priority over a write of 0 in the same cycle.
- R10: While reset is held, tx_en_o, txdom_o, rxshort_o, rxonly_o and irq_o are all 0. At the first edge after reset is released, tx_en_o becomes 1 if normal_mode_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| normal_mode_i | input | 1 | 1 = normal mode; the transmitter may drive |
| txd_i | input | 1 | Transmit data from the controller, 0 = dominant |
| rxd_i | input | 1 | Receive data line |
| short_det_i | input | 1 | Receive-line short reported by the analog sensor |
| stat_rd_i | input | 1 | One-cycle strobe: status register read |
| irq_mask_i | input | 1 | LIN interrupt mask bit, 1 = interrupt enabled |
| rxonly_we_i | input | 1 | Write strobe for the receive-only bit |
| rxonly_wd_i | input | 1 | Write data for the receive-only bit |
| tx_en_o | output | 1 | Transmit driver enable |
| txdom_o | output | 1 | Sticky flag: dominant timeout |
| rxshort_o | output | 1 | Sticky flag: receive-line short |
| rxonly_o | output | 1 | Receive-only bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with TIMEOUT set to 4. With that value, a full trip, a run that ends one cycle short of the limit, and a release all fit in a few clock cycles, so each cycle around the limit is checked exactly. Shorts are applied with RxD held steady, with TxD low, and then with a real RxD change. This shows that the release needs all three of its conditions. Status reads are placed both during and after each fault to check the conditional clearing.

// File: rtl/lin_fault_pkg.sv
package lin_fault_pkg;

  typedef struct packed {
    logic dom;
    logic shrt;
  } fault_flags_t;

  function automatic logic any_flag(input fault_flags_t f);
    return f.dom | f.shrt;
  endfunction

endpackage

// File: rtl/lin_dom_timer.sv
module lin_dom_timer #(
  parameter int TIMEOUT = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic txd,
  output logic trip,
  output logic blk_d,
  output logic blk_q
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] TOP  = CW'(TIMEOUT);

  logic [CW-1:0] cnt;

  // one-cycle pulse on the edge that completes the low run
  assign trip  = ~txd & (cnt == LAST);
  assign blk_d = txd ? 1'b0 : (trip | blk_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      blk_q <= 1'b0;
    end else begin
      blk_q <= blk_d;
      if (txd)
        cnt <= '0;
      else if (cnt != TOP)
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lin_short_guard.sv
module lin_short_guard (
  input  logic clk,
  input  logic rst,
  input  logic txd,
  input  logic rxd,
  input  logic short_det,
  output logic blk_d,
  output logic blk_q
);
  logic rxd_q;
  logic rearm;

  assign rearm = txd & (rxd != rxd_q);
  assign blk_d = short_det | (blk_q & ~rearm);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_q <= 1'b1;
      blk_q <= 1'b0;
    end else begin
      rxd_q <= rxd;
      blk_q <= blk_d;
    end
  end

endmodule

// File: rtl/lin_fault_regs.sv
module lin_fault_regs
  import lin_fault_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic normal_mode,
  input  logic txd,
  input  logic short_det,
  input  logic stat_rd,
  input  logic irq_mask,
  input  logic rxonly_we,
  input  logic rxonly_wd,
  input  logic dom_trip,
  input  logic dom_blk,
  input  logic shr_blk,
  output logic tx_en,
  output logic txdom,
  output logic rxshort,
  output logic rxonly,
  output logic irq
);
  fault_flags_t flags_q, flags_d;
  logic rxonly_q, rxonly_d;
  logic tx_en_q, irq_q;

  always_comb begin
    flags_d.dom  = dom_trip  | (flags_q.dom  & ~(stat_rd & txd));
    flags_d.shrt = short_det | (flags_q.shrt & ~stat_rd);
    if (dom_trip | short_det)
      rxonly_d = 1'b1;
    else if (rxonly_we)
      rxonly_d = rxonly_wd;
    else
      rxonly_d = rxonly_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      rxonly_q <= 1'b0;
      tx_en_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      rxonly_q <= rxonly_d;
      tx_en_q  <= normal_mode & ~rxonly_d & ~dom_blk & ~shr_blk;
      irq_q    <= irq_mask & any_flag(flags_d);
    end
  end

  assign tx_en   = tx_en_q;
  assign txdom   = flags_q.dom;
  assign rxshort = flags_q.shrt;
  assign rxonly  = rxonly_q;
  assign irq     = irq_q;

endmodule

// File: rtl/lin_txfault_sup.sv
module lin_txfault_sup #(
  parameter int TIMEOUT = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic normal_mode_i,
  input  logic txd_i,
  input  logic rxd_i,
  input  logic short_det_i,
  input  logic stat_rd_i,
  input  logic irq_mask_i,
  input  logic rxonly_we_i,
  input  logic rxonly_wd_i,
  output logic tx_en_o,
  output logic txdom_o,
  output logic rxshort_o,
  output logic rxonly_o,
  output logic irq_o
);
  logic dom_trip, dom_blk_d, dom_blk_q;
  logic shr_blk_d, shr_blk_q;

  lin_dom_timer #(.TIMEOUT(TIMEOUT)) u_dom (
    .clk   (clk),
    .rst   (rst),
    .txd   (txd_i),
    .trip  (dom_trip),
    .blk_d (dom_blk_d),
    .blk_q (dom_blk_q)
  );

  lin_short_guard u_shr (
    .clk       (clk),
    .rst       (rst),
    .txd       (txd_i),
    .rxd       (rxd_i),
    .short_det (short_det_i),
    .blk_d     (shr_blk_d),
    .blk_q     (shr_blk_q)
  );

  lin_fault_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .normal_mode (normal_mode_i),
    .txd         (txd_i),
    .short_det   (short_det_i),
    .stat_rd     (stat_rd_i),
    .irq_mask    (irq_mask_i),
    .rxonly_we   (rxonly_we_i),
    .rxonly_wd   (rxonly_wd_i),
    .dom_trip    (dom_trip),
    .dom_blk     (dom_blk_d),
    .shr_blk     (shr_blk_d),
    .tx_en       (tx_en_o),
    .txdom       (txdom_o),
    .rxshort     (rxshort_o),
    .rxonly      (rxonly_o),
    .irq         (irq_o)
  );

endmodule

// File: rtl/lin_txfault_sup_chk.sv
module lin_txfault_sup_chk #(
  parameter int TIMEOUT = 50_000_000
) (
  input logic clk,
  input logic rst,
  input logic normal_mode_i,
  input logic txd_i,
  input logic short_det_i,
  input logic stat_rd_i,
  input logic irq_mask_i,
  input logic tx_en_o,
  input logic txdom_o,
  input logic rxshort_o,
  input logic rxonly_o,
  input logic irq_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)
      low_run <= '0;
    else if (txd_i)
      low_run <= '0;
    else if (low_run != CW'(TIMEOUT))
      low_run <= low_run + 1'b1;
  end

  a_r1_trip: assert property (@(posedge clk) disable iff (rst)
    (!txd_i && low_run == CW'(TIMEOUT - 1)) |=> (txdom_o && !tx_en_o));

  a_r3_hold_low: assert property (@(posedge clk) disable iff (rst)
    (txdom_o && !txd_i) |=> txdom_o);

  a_r4_short_off: assert property (@(posedge clk) disable iff (rst)
    short_det_i |=> (!tx_en_o && rxshort_o));

  a_r6_hold_short: assert property (@(posedge clk) disable iff (rst)
    (rxshort_o && short_det_i && stat_rd_i) |=> rxshort_o);

  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    !irq_mask_i |=> !irq_o);

  a_r7_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (txdom_o || rxshort_o));

  a_r8_rxonly_off: assert property (@(posedge clk) disable iff (rst)
    rxonly_o |-> !tx_en_o);

  a_r8_mode_off: assert property (@(posedge clk) disable iff (rst)
    !normal_mode_i |=> !tx_en_o);

endmodule

bind lin_txfault_sup lin_txfault_sup_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .normal_mode_i (normal_mode_i),
  .txd_i         (txd_i),
  .short_det_i   (short_det_i),
  .stat_rd_i     (stat_rd_i),
  .irq_mask_i    (irq_mask_i),
  .tx_en_o       (tx_en_o),
  .txdom_o       (txdom_o),
  .rxshort_o     (rxshort_o),
  .rxonly_o      (rxonly_o),
  .irq_o         (irq_o)
);

// File: tb/lin_txfault_sup_bench.sv
module lin_txfault_sup_bench;
  localparam int TO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic normal_mode_i = 1'b1, txd_i = 1'b1, rxd_i = 1'b1, short_det_i = 1'b0;
  logic stat_rd_i = 1'b0, irq_mask_i = 1'b0, rxonly_we_i = 1'b0, rxonly_wd_i = 1'b0;
  logic tx_en_o, txdom_o, rxshort_o, rxonly_o, irq_o;

  always #10 clk = ~clk;

  lin_txfault_sup #(.TIMEOUT(TO)) u_lin_txfault_sup (
    .clk(clk), .rst(rst), .normal_mode_i(normal_mode_i), .txd_i(txd_i),
    .rxd_i(rxd_i), .short_det_i(short_det_i), .stat_rd_i(stat_rd_i),
    .irq_mask_i(irq_mask_i), .rxonly_we_i(rxonly_we_i), .rxonly_wd_i(rxonly_wd_i),
    .tx_en_o(tx_en_o), .txdom_o(txdom_o), .rxshort_o(rxshort_o),
    .rxonly_o(rxonly_o), .irq_o(irq_o)
  );

  typedef struct {
    logic       chk;
    logic [4:0] exp;   // {tx_en, txdom, rxshort, rxonly, irq}
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // driver: queue the expectation for the coming edge, then move on a cycle
  task automatic step(input logic chk, input logic [4:0] exp, input string tag);
    item_t it;
    it.chk = chk; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    stat_rd_i   = 1'b0;
    rxonly_we_i = 1'b0;
  endtask

  // monitor: compare at mid-high after each edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = q.pop_front();
      act = {tx_en_o, txdom_o, rxshort_o, rxonly_o, irq_o};
      if (it.chk) begin
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10 reset state
    step(1, 5'b00000, "R10 reset");
    step(1, 5'b00000, "R10 reset");
    rst = 1'b0;
    step(1, 5'b10000, "R10 enable after reset");

    // R1: TIMEOUT-1 low edges do nothing, the next one trips
    txd_i = 1'b0;
    for (int i = 0; i < TO - 1; i++) step(1, 5'b10000, "R1 below limit");
    step(1, 5'b01010, "R1 trip / R9 auto rxonly");
    // R2/R3: clear rxonly and read while still low
    rxonly_we_i = 1'b1; rxonly_wd_i = 1'b0; stat_rd_i = 1'b1;
    step(1, 5'b01000, "R3 read while low keeps flag / R2 still blocked");
    txd_i = 1'b1;
    step(1, 5'b11000, "R2 re-enable on TxD high");
    stat_rd_i = 1'b1;
    step(1, 5'b10000, "R3 read with TxD high clears");

    // R7 with mask set
    irq_mask_i = 1'b1; txd_i = 1'b0;
    for (int i = 0; i < TO - 1; i++) step(1, 5'b10000, "R1 below limit again");
    step(1, 5'b01011, "R7 irq on trip");
    irq_mask_i = 1'b0;
    step(1, 5'b01010, "R7 mask off drops irq");
    irq_mask_i = 1'b1;
    step(1, 5'b01011, "R7 mask on raises irq");
    txd_i = 1'b1; rxonly_we_i = 1'b1; rxonly_wd_i = 1'b0;
    step(1, 5'b11001, "R2 R8 re-enable, irq held");
    stat_rd_i = 1'b1;
    step(1, 5'b10000, "R7 irq falls with flag");

    // R4..R6 short handling, mask off
    irq_mask_i = 1'b0; short_det_i = 1'b1;
    step(1, 5'b00110, "R4 short sets flag, tx off");
    stat_rd_i = 1'b1; rxonly_we_i = 1'b1; rxonly_wd_i = 1'b0;
    step(1, 5'b00110, "R6 read during short / R9 set beats write");
    short_det_i = 1'b0; rxonly_we_i = 1'b1; rxonly_wd_i = 1'b0;
    step(1, 5'b00100, "R5 no RxD change keeps blocked");
    txd_i = 1'b0; rxd_i = 1'b0;
    step(1, 5'b00100, "R5 RxD change with TxD low keeps blocked");
    txd_i = 1'b1;
    step(1, 5'b00100, "R5 TxD high but no new RxD change");
    rxd_i = 1'b1;
    step(1, 5'b10100, "R5 release on RxD change with TxD high");
    stat_rd_i = 1'b1;
    step(1, 5'b10000, "R6 read after short clears");

    // R8 receive-only and mode
    rxonly_we_i = 1'b1; rxonly_wd_i = 1'b1;
    step(1, 5'b00010, "R8 rxonly write 1");
    rxonly_we_i = 1'b1; rxonly_wd_i = 1'b0;
    step(1, 5'b10000, "R8 rxonly write 0");
    normal_mode_i = 1'b0;
    step(1, 5'b00000, "R8 not normal mode");
    normal_mode_i = 1'b1;
    step(1, 5'b10000, "R8 normal mode again");

    // R7 with short flag
    irq_mask_i = 1'b1; short_det_i = 1'b1;
    step(1, 5'b00111, "R7 irq on short");
    short_det_i = 1'b0; stat_rd_i = 1'b1;
    step(1, 5'b00010, "R7 irq clears with flag, R9 rxonly kept");

    step(0, 5'b00000, "drain");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule